// File: doc/BRIEF.md
# Window Threshold Watchdog with Consecutive-Hit Filter

This block watches a stream of conversion results and checks each one against a window set by a lower and an upper threshold. When a result lands outside that window, a sticky event flag is raised. An interrupt output follows the flag when interrupts are enabled. A small filter can require a run of consecutive out-of-window results before the flag fires. This stops a single noisy sample from raising an event.

Software sets the two thresholds and a control word over a simple write port. The control word holds the filter length and the interrupt enable. Writes that would disturb a conversion in progress are dropped, and a one-cycle error strobe reports each dropped write. Software acknowledges an event with a flag-clear input.

Top module: `win_watchdog`

## Requirements
- R1: After synchronous reset, flag, irq and wr_err are 0. The lower threshold is 0, the upper threshold is all ones, the filter setting is 0 and interrupts are disabled.
- R2: A valid result is out of window only when it is strictly below the lower threshold or strictly above the upper threshold. A result equal to either threshold is in window.
- R3: With filter setting 0, the first out-of-window valid result sets flag. Flag is high from the clock edge that samples that result.
- R4: With filter setting N, flag is set by the (N+1)-th consecutive out-of-window valid result. Cycles without res_valid do not break a run.
- R5: An in-window valid result resets the run of consecutive out-of-window results to zero.
- R6: The run counter saturates at N+1. After a clear, during a continuing excursion, the next out-of-window result sets flag again.
- R7: Flag stays set until flag_clr is sampled high. If a set and a clear happen in the same cycle, the set wins.
- R8: irq equals flag AND the interrupt-enable bit. The interrupt-enable bit is bit FILT_W of the control write data.
- R9: The threshold writes are wr_sel=0 for the lower threshold and wr_sel=1 for the upper threshold. They are ignored while reg_conv_active or inj_conv_active is high.
- R10: The control write is wr_sel=2. Bits [FILT_W-1:0] hold the filter setting and bit FILT_W holds the interrupt enable. It is ignored while reg_conv_active is high, and it is accepted while only inj_conv_active is high.
- R11: Each ignored write makes wr_err high for exactly the cycle after it. wr_sel=3 is reserved: it changes nothing and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Result strobe |
| res_data | input | DATA_W | Conversion result |
| reg_conv_active | input | 1 | Regular conversion in progress |
| inj_conv_active | input | 1 | Injected conversion in progress |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Write target: 0 lower, 1 upper, 2 control, 3 reserved |
| wr_data | input | DATA_W | Write data |
| flag_clr | input | 1 | Clears the event flag |
| flag | output | 1 | Sticky out-of-window event flag |
| irq | output | 1 | Interrupt: flag gated by enable |
| wr_err | output | 1 | One-cycle strobe for a dropped write |

## Verification
The bench targets results that sit exactly on a threshold. A design that compares with non-strict inequalities would flag these results. It also targets runs that are broken by one in-window sample, and runs that are padded with idle cycles. A miscounted or wrongly reset run counter would fire too early, too late, or not at all. A set and a clear landing in the same cycle, and long excursions past the filter length, expose a lost event or a wrapping counter. Writes made during each combination of active conversions show whether the two blocking rules have been mixed up, whether blocked data leaks into the registers, and whether the error strobe is missing.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_RSVD = 2'd3
  } wsel_e;
endpackage

// File: rtl/wdg_cfg_regs.sv
module wdg_cfg_regs
  import wdg_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int FILT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              reg_active,
  input  logic              inj_active,
  output logic [DATA_W-1:0] lo_thr,
  output logic [DATA_W-1:0] hi_thr,
  output logic [FILT_W-1:0] filt,
  output logic              irq_en,
  output logic              wr_err
);
  wsel_e sel;
  logic  thr_wr, ctl_wr, thr_blk, ctl_blk;

  always_comb begin
    sel     = wsel_e'(wr_sel);
    thr_blk = reg_active | inj_active;
    ctl_blk = reg_active;
    thr_wr  = wr_en && (sel == SEL_LO || sel == SEL_HI);
    ctl_wr  = wr_en && (sel == SEL_CTRL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_thr <= '0;
      hi_thr <= '1;
      filt   <= '0;
      irq_en <= 1'b0;
      wr_err <= 1'b0;
    end else begin
      wr_err <= (thr_wr && thr_blk) || (ctl_wr && ctl_blk);
      if (thr_wr && !thr_blk) begin
        if (sel == SEL_LO) lo_thr <= wr_data;
        else               hi_thr <= wr_data;
      end
      if (ctl_wr && !ctl_blk) begin
        filt   <= wr_data[FILT_W-1:0];
        irq_en <= wr_data[FILT_W];
      end
    end
  end

  AST_LO_HELD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0 && (reg_active || inj_active)) |=> $stable(lo_thr)); // R9
  AST_CTL_HELD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd2 && reg_active) |=> ($stable(filt) && $stable(irq_en))); // R10
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> $past(wr_en)); // R11
endmodule

// File: rtl/wdg_run_filter.sv
module wdg_run_filter #(
  parameter int DATA_W = 12,
  parameter int FILT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic [DATA_W-1:0] lo_thr,
  input  logic [DATA_W-1:0] hi_thr,
  input  logic [FILT_W-1:0] filt,
  input  logic              flag_clr,
  output logic              flag
);
  localparam int RUN_W = FILT_W + 1;

  logic [RUN_W-1:0] run, need, run_inc;
  logic             out_win, hit;

  always_comb begin
    need    = RUN_W'(filt) + RUN_W'(1);
    out_win = (res_data < lo_thr) || (res_data > hi_thr);
    run_inc = (run >= need) ? need : run + RUN_W'(1);
    hit     = res_valid && out_win && (run_inc >= need);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= '0;
      flag <= 1'b0;
    end else begin
      if (res_valid) run <= out_win ? run_inc : '0;
      if (hit)           flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  AST_INWIN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !out_win) |=> (run == '0)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag); // R7
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(res_valid)); // R4
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (res_valid && out_win && run != '0) |=> (run != '0)); // R6
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int DATA_W = 12,
  parameter int FILT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              reg_conv_active,
  input  logic              inj_conv_active,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flag_clr,
  output logic              flag,
  output logic              irq,
  output logic              wr_err
);
  logic [DATA_W-1:0] lo_thr, hi_thr;
  logic [FILT_W-1:0] filt;
  logic              irq_en;

  wdg_cfg_regs #(.DATA_W(DATA_W), .FILT_W(FILT_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .reg_active(reg_conv_active), .inj_active(inj_conv_active),
    .lo_thr(lo_thr), .hi_thr(hi_thr), .filt(filt), .irq_en(irq_en),
    .wr_err(wr_err)
  );

  wdg_run_filter #(.DATA_W(DATA_W), .FILT_W(FILT_W)) u_filt (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .lo_thr(lo_thr), .hi_thr(hi_thr), .filt(filt), .flag_clr(flag_clr),
    .flag(flag)
  );

  assign irq = flag & irq_en;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag); // R8
endmodule

// File: tb/win_watchdog_bench.sv
module win_watchdog_bench;
  localparam int DW = 12;
  localparam int FW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rv = 0, ra = 0, ia = 0, we = 0, fc = 0;
  logic [DW-1:0] rd = '0, wd = '0;
  logic [1:0] ws = '0;
  logic flag, irq, wr_err;

  always #2.5 clk = ~clk;

  win_watchdog #(.DATA_W(DW), .FILT_W(FW)) u_win_watchdog (
    .clk(clk), .rst(rst), .res_valid(rv), .res_data(rd),
    .reg_conv_active(ra), .inj_conv_active(ia), .wr_en(we), .wr_sel(ws),
    .wr_data(wd), .flag_clr(fc), .flag(flag), .irq(irq), .wr_err(wr_err)
  );

  int checks = 0, fails = 0;
  string tag = "R1";
  int m_lo, m_hi, m_filt, m_run;
  bit m_ie, m_flag, m_err;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    if (rst) begin
      m_lo = 0; m_hi = (1 << DW) - 1; m_filt = 0; m_ie = 0;
      m_flag = 0; m_err = 0; m_run = 0;
    end else begin
      int need = m_filt + 1;
      bit out = (int'(rd) < m_lo) || (int'(rd) > m_hi);
      bit setf = 0;
      if (rv) begin
        if (out) begin
          m_run = (m_run >= need) ? need : m_run + 1;
          setf = (m_run >= need);
        end else m_run = 0;
      end
      if (setf) m_flag = 1; else if (fc) m_flag = 0;
      m_err = we && ((ws < 2 && (ra || ia)) || (ws == 2 && ra));
      if (we && ws < 2 && !(ra || ia)) begin
        if (ws == 0) m_lo = int'(wd); else m_hi = int'(wd);
      end
      if (we && ws == 2 && !ra) begin
        m_filt = int'(wd[FW-1:0]); m_ie = wd[FW];
      end
    end
    @(negedge clk);
    chk("flag", int'(flag), int'(m_flag));
    chk("irq", int'(irq), int'(m_flag && m_ie));
    chk("wr_err", int'(wr_err), int'(m_err));
    rv = 0; we = 0; fc = 0;
  endtask

  task automatic res(int d);
    rv = 1; rd = DW'(d); tick();
  endtask
  task automatic wr(int s, int d);
    we = 1; ws = 2'(s); wd = DW'(d); tick();
  endtask
  task automatic clr();
    fc = 1; tick();
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    rst = 0;
    tag = "R1"; tick();
    res(0); res((1 << DW) - 1);

    tag = "R2";
    wr(0, 100); wr(1, 200); wr(2, 8);
    res(100); res(200);
    tag = "R3"; res(99); tick(); clr(); res(201); clr();

    tag = "R4"; wr(2, 8 | 3);
    res(5); tick(); res(5); tick(); tick(); res(300); res(300); clr();
    tag = "R5";
    res(5); res(5); res(5); res(150); res(5); res(5); res(5); res(150);
    res(5); res(5); res(5); res(5); clr();

    tag = "R6"; wr(2, 8 | 7);
    for (int i = 0; i < 9; i++) res(250);
    tag = "R7"; fc = 1; res(250); tick(); tick(); clr();
    tag = "R6"; res(250); clr(); res(150); res(250); tick();
    tag = "R8"; wr(2, 7); tick(); wr(2, 8 | 7); tick(); clr();

    tag = "R9";
    ra = 1; wr(0, 50); ra = 0; ia = 1; wr(1, 120); ia = 0;
    wr(2, 8); res(60); res(130); clr();
    tag = "R10";
    ia = 1; wr(2, 8 | 2); ia = 0; res(60); res(60); res(60); clr();
    ra = 1; wr(2, 8 | 0); ra = 0; res(60); res(60); res(60); clr();
    tag = "R11";
    ra = 1; wr(0, 1); wr(0, 2); ra = 0; tick();
    wr(3, 4095); tick(); wr(2, 8); res(100); res(200); res(99); clr(); tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule